// File: doc/BRIEF.md
# Banked Register-File Address Decoder

This block sits between a small RISC core and its data memory. Each access arrives either as a 7-bit in-bank offset plus a 2-bit bank number (direct mode) or as a full 9-bit address that the core formed elsewhere (indirect mode). The block resolves that address to one canonical location and decides whether it falls in the special-function window or in general-purpose RAM. The general-purpose RAM is held inside the block.

Two kinds of sharing fold addresses onto bank 0. The top sixteen offsets of every bank (70h to 7Fh) are one common RAM area. A parameter mask also names special-function offsets that reach the same register from any bank. Special-function accesses are passed out as a canonical address with read and write strobes. The register contents come back on a data input and are forwarded on the read port. RAM writes take effect at the clock edge, and RAM reads are combinational.

Top module: `dmem_bank_decoder`

## Requirements
- R1: The resolved address keeps the in-bank offset unchanged. In direct mode (`ind_en_i`=0) the offset is `ofs_i` and the bank is `bank_sel_i`. In indirect mode the offset is `ind_addr_i[6:0]` and the bank is `ind_addr_i[8:7]`. `mem_addr_o` is {bank, offset}, except where R2 or R4 forces the bank to 0.
- R2: Any offset from 70h to 7Fh resolves to bank 0, whatever the bank select.
- R3: `sfr_sel_o` is 1 exactly when the offset is below `SFR_BOUND` (default 20h). Offsets from 20h to 6Fh are private RAM for each bank.
- R4: The offsets set in `MIRROR_MASK` (default 00h, 02h, 03h, 04h, 0Ah, 0Bh) resolve to bank 0. Every other special-function offset keeps its bank.
- R5: `sfr_wr_o` equals `wr_en_i` and `sfr_sel_o`. `sfr_rd_o` equals `rd_en_i` and `sfr_sel_o`. A special-function write never changes RAM.
- R6: A RAM write is stored at the clock edge. A read in the same cycle returns the old value, and a read in the next cycle returns the new one.
- R7: `rdata_o` is 0 when `rd_en_i` is low. It equals `sfr_rdata_i` on a special-function read and the stored byte on a RAM read.
- R8: Offsets 20h to 6Fh in the four banks are four separate storage areas.
- R9: Reset clears every RAM byte to 0.
- R10: A write at 70h to 7Fh through any bank is read back through every other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears RAM |
| ofs_i | input | 7 | Direct-mode in-bank offset |
| bank_sel_i | input | 2 | Direct-mode bank number |
| ind_en_i | input | 1 | 1 selects the indirect address |
| ind_addr_i | input | 9 | Full address for indirect mode |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| sfr_rdata_i | input | 8 | Data returned by the special-function registers |
| rdata_o | output | 8 | Read data |
| mem_addr_o | output | 9 | Canonical resolved address |
| sfr_sel_o | output | 1 | Access falls in the special-function window |
| sfr_rd_o | output | 1 | Special-function read strobe |
| sfr_wr_o | output | 1 | Special-function write strobe |

## Verification
The assertions assume that every input is stable and known for the whole cycle around each rising edge. They also assume that `sfr_rdata_i` depends only on the current address. The write-then-read property further assumes that RAM is changed only by this block's own write port.

The bench drives every input one time unit after the rising edge and leaves it unchanged until the next edge. It sets `sfr_rdata_i` from the offset being accessed. It holds both strobes low during reset, so the assumed conditions hold in every cycle the properties see.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    // Region an access falls into after resolution
    typedef enum logic [0:0] {
        RGN_GPR = 1'b0,
        RGN_SFR = 1'b1
    } region_e;

endpackage

// File: rtl/dmem_addr_former.sv
// Chooses between the direct {bank, offset} pair and the indirect 9-bit address.
module dmem_addr_former #(
    parameter int OFS_W  = 7,
    parameter int BANK_W = 2
) (
    input  logic [OFS_W-1:0]        ofs_i,
    input  logic [BANK_W-1:0]       bank_sel_i,
    input  logic                    ind_en_i,
    input  logic [BANK_W+OFS_W-1:0] ind_addr_i,
    output logic [OFS_W-1:0]        raw_ofs_o,
    output logic [BANK_W-1:0]       raw_bank_o
);

    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [BANK_W-1:0] bank;
    } raw_t;

    raw_t raw_d;

    always_comb begin
        raw_d = '0;
        if (ind_en_i) begin
            raw_d.ofs  = ind_addr_i[OFS_W-1:0];
            raw_d.bank = ind_addr_i[BANK_W+OFS_W-1:OFS_W];
        end else begin
            raw_d.ofs  = ofs_i;
            raw_d.bank = bank_sel_i;
        end
    end

    assign raw_ofs_o  = raw_d.ofs;
    assign raw_bank_o = raw_d.bank;

endmodule

// File: rtl/dmem_region_decode.sv
// Folds shared and mirrored offsets onto bank 0 and computes the RAM index.
module dmem_region_decode
    import dmem_pkg::*;
#(
    parameter int OFS_W       = 7,
    parameter int BANK_W      = 2,
    parameter int SFR_BOUND   = 32,
    parameter int SHARED_BASE = 112,
    parameter logic [SFR_BOUND-1:0] MIRROR_MASK = 32'h0000_0C1D,
    parameter int IDX_W       = 9
) (
    input  logic [OFS_W-1:0]  raw_ofs_i,
    input  logic [BANK_W-1:0] raw_bank_i,
    output logic [BANK_W-1:0] canon_bank_o,
    output region_e           region_o,
    output logic [IDX_W-1:0]  gpr_idx_o
);

    localparam int NBANKS = 1 << BANK_W;
    localparam int PRIV   = SHARED_BASE - SFR_BOUND;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        region_e           region;
        logic [IDX_W-1:0]  idx;
    } dec_t;

    logic [SFR_BOUND-1:0] mirror_hit;
    logic                 in_shared;
    logic                 is_mirror;
    dec_t                 dec_d;

    // one comparator per special-function offset named in the mask
    for (genvar k = 0; k < SFR_BOUND; k++) begin : g_mirror
        if (MIRROR_MASK[k]) begin : g_on
            assign mirror_hit[k] = (int'(raw_ofs_i) == k);
        end else begin : g_off
            assign mirror_hit[k] = 1'b0;
        end
    end

    assign is_mirror = |mirror_hit;
    assign in_shared = (int'(raw_ofs_i) >= SHARED_BASE);

    always_comb begin
        int idx_int;
        dec_d   = '0;
        idx_int = 0;
        if (int'(raw_ofs_i) < SFR_BOUND) begin
            dec_d.region = RGN_SFR;
            dec_d.bank   = is_mirror ? '0 : raw_bank_i;
        end else if (in_shared) begin
            dec_d.region = RGN_GPR;
            dec_d.bank   = '0;
            idx_int      = NBANKS * PRIV + int'(raw_ofs_i) - SHARED_BASE;
        end else begin
            dec_d.region = RGN_GPR;
            dec_d.bank   = raw_bank_i;
            idx_int      = int'(raw_bank_i) * PRIV + int'(raw_ofs_i) - SFR_BOUND;
        end
        dec_d.idx = IDX_W'(idx_int);
    end

    assign canon_bank_o = dec_d.bank;
    assign region_o     = dec_d.region;
    assign gpr_idx_o    = dec_d.idx;

endmodule

// File: rtl/dmem_gpr_store.sv
// General-purpose RAM: write at the edge, combinational read.
module dmem_gpr_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 336,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] cells;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i && (int'(idx_i) < DEPTH)) begin
            st_d.cells[idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = (int'(idx_i) < DEPTH) ? st_q.cells[idx_i] : '0;

endmodule

// File: rtl/dmem_bank_decoder.sv
module dmem_bank_decoder
    import dmem_pkg::*;
#(
    parameter int OFS_W       = 7,
    parameter int BANK_W      = 2,
    parameter int DATA_W      = 8,
    parameter int SFR_BOUND   = 32,
    parameter int SHARED_BASE = 112,
    parameter logic [SFR_BOUND-1:0] MIRROR_MASK = 32'h0000_0C1D
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OFS_W-1:0]        ofs_i,
    input  logic [BANK_W-1:0]       bank_sel_i,
    input  logic                    ind_en_i,
    input  logic [BANK_W+OFS_W-1:0] ind_addr_i,
    input  logic                    rd_en_i,
    input  logic                    wr_en_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [DATA_W-1:0]       sfr_rdata_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [BANK_W+OFS_W-1:0] mem_addr_o,
    output logic                    sfr_sel_o,
    output logic                    sfr_rd_o,
    output logic                    sfr_wr_o
);

    localparam int NBANKS = 1 << BANK_W;
    localparam int SPAN   = 1 << OFS_W;
    localparam int DEPTH  = NBANKS * (SHARED_BASE - SFR_BOUND) + (SPAN - SHARED_BASE);
    localparam int IDX_W  = $clog2(DEPTH);

    typedef struct packed {
        logic [DATA_W-1:0]       rdata;
        logic [BANK_W+OFS_W-1:0] addr;
        logic                    sel;
        logic                    srd;
        logic                    swr;
        logic                    gwe;
    } port_t;

    logic [OFS_W-1:0]  raw_ofs;
    logic [BANK_W-1:0] raw_bank;
    logic [BANK_W-1:0] canon_bank;
    region_e           region;
    logic [IDX_W-1:0]  gpr_idx;
    logic [DATA_W-1:0] gpr_rdata;
    port_t             out_d;

    dmem_addr_former #(
        .OFS_W (OFS_W),
        .BANK_W(BANK_W)
    ) u_former (
        .ofs_i     (ofs_i),
        .bank_sel_i(bank_sel_i),
        .ind_en_i  (ind_en_i),
        .ind_addr_i(ind_addr_i),
        .raw_ofs_o (raw_ofs),
        .raw_bank_o(raw_bank)
    );

    dmem_region_decode #(
        .OFS_W      (OFS_W),
        .BANK_W     (BANK_W),
        .SFR_BOUND  (SFR_BOUND),
        .SHARED_BASE(SHARED_BASE),
        .MIRROR_MASK(MIRROR_MASK),
        .IDX_W      (IDX_W)
    ) u_decode (
        .raw_ofs_i   (raw_ofs),
        .raw_bank_i  (raw_bank),
        .canon_bank_o(canon_bank),
        .region_o    (region),
        .gpr_idx_o   (gpr_idx)
    );

    dmem_gpr_store #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (out_d.gwe),
        .idx_i  (gpr_idx),
        .wdata_i(wdata_i),
        .rdata_o(gpr_rdata)
    );

    always_comb begin
        out_d      = '0;
        out_d.sel  = (region == RGN_SFR);
        out_d.addr = {canon_bank, raw_ofs};
        out_d.srd  = rd_en_i && out_d.sel;
        out_d.swr  = wr_en_i && out_d.sel;
        out_d.gwe  = wr_en_i && !out_d.sel;
        if (rd_en_i) begin
            out_d.rdata = out_d.sel ? sfr_rdata_i : gpr_rdata;
        end
    end

    assign rdata_o    = out_d.rdata;
    assign mem_addr_o = out_d.addr;
    assign sfr_sel_o  = out_d.sel;
    assign sfr_rd_o   = out_d.srd;
    assign sfr_wr_o   = out_d.swr;

endmodule

// File: rtl/dmem_bank_decoder_chk.sv
module dmem_bank_decoder_chk #(
    parameter int OFS_W       = 7,
    parameter int BANK_W      = 2,
    parameter int DATA_W      = 8,
    parameter int SFR_BOUND   = 32,
    parameter int SHARED_BASE = 112,
    parameter logic [SFR_BOUND-1:0] MIRROR_MASK = 32'h0000_0C1D
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [OFS_W-1:0]        ofs_i,
    input logic [BANK_W-1:0]       bank_sel_i,
    input logic                    ind_en_i,
    input logic [BANK_W+OFS_W-1:0] ind_addr_i,
    input logic                    rd_en_i,
    input logic                    wr_en_i,
    input logic [DATA_W-1:0]       wdata_i,
    input logic [DATA_W-1:0]       sfr_rdata_i,
    input logic [DATA_W-1:0]       rdata_o,
    input logic [BANK_W+OFS_W-1:0] mem_addr_o,
    input logic                    sfr_sel_o,
    input logic                    sfr_rd_o,
    input logic                    sfr_wr_o
);

    logic [OFS_W-1:0]  eff_ofs;
    logic [BANK_W-1:0] eff_bank;
    logic              mir;
    logic              past_ok;

    assign eff_ofs  = ind_en_i ? ind_addr_i[OFS_W-1:0] : ofs_i;
    assign eff_bank = ind_en_i ? ind_addr_i[BANK_W+OFS_W-1:OFS_W] : bank_sel_i;

    always_comb begin
        mir = 1'b0;
        for (int k = 0; k < SFR_BOUND; k++) begin
            if (int'(eff_ofs) == k && MIRROR_MASK[k]) mir = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1: offset passes through unchanged
    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr_o[OFS_W-1:0] == eff_ofs);

    // R1: an unshared, unmirrored offset keeps its bank
    assert_bank_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(eff_ofs) < SHARED_BASE && !mir) |-> mem_addr_o[BANK_W+OFS_W-1:OFS_W] == eff_bank);

    assert_shared_bank0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(eff_ofs) >= SHARED_BASE) |-> mem_addr_o[BANK_W+OFS_W-1:OFS_W] == '0);

    assert_sfr_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_sel_o == (int'(eff_ofs) < SFR_BOUND));

    assert_mirror_bank0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mir |-> (sfr_sel_o && mem_addr_o[BANK_W+OFS_W-1:OFS_W] == '0));

    assert_strobe_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd_o || sfr_wr_o) |-> sfr_sel_o);

    assert_write_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en_i && !sfr_sel_o) && rd_en_i && !sfr_sel_o
         && mem_addr_o == $past(mem_addr_o)) |-> rdata_o == $past(wdata_i));

    assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> rdata_o == '0);

    assert_sfr_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rd_o |-> rdata_o == sfr_rdata_i);

endmodule

bind dmem_bank_decoder dmem_bank_decoder_chk #(
    .OFS_W      (OFS_W),
    .BANK_W     (BANK_W),
    .DATA_W     (DATA_W),
    .SFR_BOUND  (SFR_BOUND),
    .SHARED_BASE(SHARED_BASE),
    .MIRROR_MASK(MIRROR_MASK)
) u_chk (.*);

// File: tb/tb_dmem_bank_decoder.sv
`timescale 1ns/1ps
module tb_dmem_bank_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ofs_i = '0;
    logic [1:0] bank_sel_i = '0;
    logic       ind_en_i = 1'b0;
    logic [8:0] ind_addr_i = '0;
    logic       rd_en_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] sfr_rdata_i = '0;
    logic [7:0] rdata_o;
    logic [8:0] mem_addr_o;
    logic       sfr_sel_o, sfr_rd_o, sfr_wr_o;

    always #2.5 clk = ~clk;

    dmem_bank_decoder dut (.*);

    typedef struct {
        logic [8:0] addr;
        logic       sel, srd, swr;
        logic [7:0] rd;
        string      tag;
    } item_t;

    item_t      sb[$];
    logic [7:0] model[512];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    function automatic bit is_mirror(input logic [6:0] o);
        return (o == 7'h00 || o == 7'h02 || o == 7'h03 || o == 7'h04 || o == 7'h0A || o == 7'h0B);
    endfunction

    function automatic logic [8:0] canon(input logic [1:0] b, input logic [6:0] o);
        if (o >= 7'h70 || (o < 7'h20 && is_mirror(o))) return {2'b00, o};
        return {b, o};
    endfunction

    // driver: applies one access for one cycle and queues what must appear
    task automatic acc(input bit ind, input logic [1:0] b, input logic [6:0] o,
                       input bit r, input bit w, input logic [7:0] wd, input string tag);
        item_t      it;
        logic [1:0] eb;
        logic [6:0] eo;
        @(posedge clk);
        #1;
        ind_en_i    = ind;
        ind_addr_i  = ind ? {b, o} : 9'h1A5;
        bank_sel_i  = ind ? ~b : b;
        ofs_i       = ind ? ~o : o;
        rd_en_i     = r;
        wr_en_i     = w;
        wdata_i     = wd;
        eb          = b;
        eo          = o;
        sfr_rdata_i = 8'hC3 ^ {1'b0, eo};
        it.addr = canon(eb, eo);
        it.sel  = (eo < 7'h20);
        it.srd  = r && it.sel;
        it.swr  = w && it.sel;
        it.rd   = !r ? 8'h00 : (it.sel ? sfr_rdata_i : model[it.addr]);
        it.tag  = tag;
        sb.push_back(it);
        if (w && !it.sel) model[it.addr] = wd;
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle, away from the clock edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            cmp(it.tag, "mem_addr", int'(mem_addr_o), int'(it.addr));
            cmp(it.tag, "sfr_sel", int'(sfr_sel_o), int'(it.sel));
            cmp(it.tag, "sfr_rd", int'(sfr_rd_o), int'(it.srd));
            cmp(it.tag, "sfr_wr", int'(sfr_wr_o), int'(it.swr));
            cmp(it.tag, "rdata", int'(rdata_o), int'(it.rd));
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        for (int i = 0; i < 512; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: RAM is zero after reset, checked across regions
        acc(0, 2'd0, 7'h20, 1, 0, 0, "R9");
        acc(0, 2'd3, 7'h6F, 1, 0, 0, "R9");
        acc(0, 2'd2, 7'h7F, 1, 0, 0, "R9");

        // R10 / R2: shared area written in one bank, read in all others
        for (int b = 0; b < 4; b++) begin
            acc(0, 2'(b), 7'h70 + 7'(b), 1, 1, 8'h10 + 8'(b), "R10");
            for (int r = 0; r < 4; r++)
                acc(0, 2'(r), 7'h70 + 7'(b), 1, 0, 0, "R10");
        end
        acc(0, 2'd1, 7'h7F, 0, 1, 8'hEE, "R2");
        acc(0, 2'd0, 7'h7F, 1, 0, 0, "R2");

        // R6 / R8: private areas, same-cycle read sees old value
        for (int b = 0; b < 4; b++)
            acc(0, 2'(b), 7'h30, 1, 1, 8'hA0 + 8'(b), "R6");
        for (int b = 0; b < 4; b++)
            acc(0, 2'(b), 7'h30, 1, 0, 0, "R8");
        acc(0, 2'd2, 7'h20, 0, 1, 8'h5C, "R3");
        acc(0, 2'd2, 7'h1F, 1, 1, 8'h77, "R3");
        acc(0, 2'd2, 7'h20, 1, 0, 0, "R3");
        acc(0, 2'd3, 7'h6F, 0, 1, 8'h6F, "R8");
        acc(0, 2'd0, 7'h6F, 1, 0, 0, "R8");
        acc(0, 2'd3, 7'h6F, 1, 0, 0, "R8");

        // R4 / R5 / R7: special-function window, mirrored and not
        for (int b = 0; b < 4; b++) begin
            acc(0, 2'(b), 7'h03, 1, 0, 0, "R4");
            acc(0, 2'(b), 7'h0B, 0, 1, 8'h11, "R4");
            acc(0, 2'(b), 7'h01, 1, 0, 0, "R4");
            acc(0, 2'(b), 7'h0C, 0, 1, 8'h22, "R5");
        end
        acc(0, 2'd1, 7'h05, 0, 0, 0, "R7");
        acc(0, 2'd1, 7'h40, 0, 0, 0, "R7");

        // R1: indirect mode reaches the same places
        acc(1, 2'd1, 7'h45, 0, 1, 8'h9D, "R1");
        acc(0, 2'd1, 7'h45, 1, 0, 0, "R1");
        acc(1, 2'd3, 7'h72, 1, 0, 0, "R1");
        acc(1, 2'd2, 7'h04, 1, 0, 0, "R1");
        acc(1, 2'd2, 7'h06, 1, 0, 0, "R1");

        // mixed pattern over every region
        lf = 8'h5B;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            acc(lf[0] & lf[3], lf[7:6], lf[6:0] ^ 7'(i), lf[1] | lf[2], lf[4], lf ^ 8'(i), "R6");
        end

        @(posedge clk);
        #1 rd_en_i = 1'b0; wr_en_i = 1'b0;
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule